// File: doc/BRIEF.md
# Sample Trim Corrector with Overrange Guard

This block trims each converted sample of a sigma-delta acquisition path. A 24-bit two's-complement result from the last filter stage is scaled by an unsigned 16-bit gain word (0x8000 is unity), then shifted by a signed 16-bit offset word, and the sum is clipped to the 24-bit range. The trimmed sample appears two clocks after it is presented.

Next to the trim path, the block raises a sticky overrange flag. There are two triggers. The first compares the output of the first decimation stage, taken before any gain or offset is applied, against a 16-bit limit word, so the flag rises with little delay. The second fires when the modulator reports more than four back-to-back samples beyond full scale. The flag holds until the status word is read.

The three setting words are loaded through a narrow select/data write port. Nothing else in the register space is handled here.

Top module: `trim_corrector`

## Requirements
- R1: After reset, outValid, overrange and outSample are 0. The gain word is 0xA000 (gain 1.25), the offset word is 0x0000 and the limit word is 0xCCCC.
- R2: The scaled value is floor(sample × gain / 2^15). The sample is signed and the gain is unsigned, so 0x8000 gives an output equal to the input.
- R3: The offset is applied after scaling. The offset word is sign-extended and doubled before it is added, so 0x7FFF adds +65534 LSB and 0x8000 adds −65536 LSB of the 24-bit result.
- R4: A sum above 0x7FFFFF gives 0x7FFFFF, and a sum below −0x800000 gives 0x800000. Neither wraps.
- R5: A sample presented with finalValid before clock edge N appears on outSample with outValid high after edge N+1. outValid is high for exactly one cycle per sample.
- R6: When cfgWrite is high at an edge, cfgSel selects the word that takes cfgData: 0 is gain, 1 is offset, 2 is limit. Select code 3 changes nothing. A new setting applies to samples presented after that edge.
- R7: An earlyValid sample whose upper 16 bits, taken as a signed value, have a magnitude m with 2·m greater than the limit word sets overrange at the next edge. Gain and offset have no effect on this test.
- R8: overrange is set at the edge where the fifth consecutive modValid sample with modOverFs high arrives. A modValid sample with modOverFs low restarts the count. Cycles without modValid leave the count unchanged.
- R9: overrange stays set until statusRead is high at an edge, which clears it. If a trigger arrives in the same cycle as the read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Write strobe for a setting word |
| cfgSel | input | 2 | Setting select: 0 gain, 1 offset, 2 limit, 3 none |
| cfgData | input | 16 | Setting value |
| finalValid | input | 1 | finalSample is valid this cycle |
| finalSample | input | 24 | Final-stage sample, two's complement |
| earlyValid | input | 1 | earlySample is valid this cycle |
| earlySample | input | 24 | First-stage sample before trim |
| modValid | input | 1 | Modulator-rate sample strobe |
| modOverFs | input | 1 | Modulator sample is beyond full scale |
| statusRead | input | 1 | Status word is being read; clears the flag |
| outValid | output | 1 | outSample is valid |
| outSample | output | 24 | Trimmed and clipped sample |
| overrange | output | 1 | Sticky overrange flag |

## Verification
The bench drives the clipping edges with the largest gain and with positive and negative full-scale inputs, and with the offset pushed past the limits. A design that wraps there returns a result of the wrong sign. It checks the early threshold at the values just below and just above it, both positive and negative: an off-by-one compare, or a magnitude taken the wrong way, moves the trip point by one code. It sends runs of exactly four and five over-range modulator samples, with idle cycles between them and with one clean sample in the middle, to catch a counter that trips one sample early or late or is reset by gaps. It also reads the status in the same cycle as a trigger, so a design that lets the clear win loses an event.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [1:0] {
    SEL_GAIN   = 2'd0,
    SEL_OFFSET = 2'd1,
    SEL_LIMIT  = 2'd2,
    SEL_SPARE  = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic loadGain;
    logic loadOffset;
    logic loadLimit;
    logic stepMul;
    logic stepSum;
  } trimStrobes_t;

endpackage

// File: rtl/trim_saturate.sv
module trim_saturate #(
  parameter int IN_W  = 27,
  parameter int OUT_W = 24
) (
  input  logic [IN_W-1:0]  valueIn,
  output logic [OUT_W-1:0] valueOut
);
  localparam int HEAD_W = IN_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [HEAD_W-1:0] head;
  logic fits;

  always_comb begin
    head = valueIn[IN_W-1:OUT_W-1];
    fits = (&head) | ~(|head);
    if (fits)
      valueOut = valueIn[OUT_W-1:0];
    else if (valueIn[IN_W-1])
      valueOut = NEG_MIN;
    else
      valueOut = POS_MAX;
  end
endmodule

// File: rtl/trim_datapath.sv
module trim_datapath
  import trim_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int COEF_W       = 16,
  parameter int GAIN_SHIFT   = 15,
  parameter int OFFSET_SHIFT = 1,
  parameter logic [COEF_W-1:0] GAIN_RESET   = 16'hA000,
  parameter logic [COEF_W-1:0] OFFSET_RESET = 16'h0000,
  parameter logic [COEF_W-1:0] LIMIT_RESET  = 16'hCCCC
) (
  input  logic              clk,
  input  logic              rstN,
  input  trimStrobes_t      strobes,
  input  logic [COEF_W-1:0] cfgData,
  input  logic [DATA_W-1:0] finalSample,
  input  logic [DATA_W-1:0] earlySample,
  output logic [DATA_W-1:0] outSample,
  output logic              earlyHit,
  output logic [COEF_W-1:0] gainNow,
  output logic [COEF_W-1:0] offsetNow,
  output logic [COEF_W-1:0] limitNow
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int SCALE_W = DATA_W + 2;
  localparam int SUM_W = SCALE_W + 1;
  localparam int OFS_PAD = SUM_W - COEF_W - OFFSET_SHIFT;

  logic [COEF_W-1:0] gainReg, offsetReg, limitReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainReg   <= GAIN_RESET;
      offsetReg <= OFFSET_RESET;
      limitReg  <= LIMIT_RESET;
    end else begin
      if (strobes.loadGain)   gainReg   <= cfgData;
      if (strobes.loadOffset) offsetReg <= cfgData;
      if (strobes.loadLimit)  limitReg  <= cfgData;
    end
  end

  assign gainNow   = gainReg;
  assign offsetNow = offsetReg;
  assign limitNow  = limitReg;

  // multiply stage: signed sample by unsigned gain, arithmetic shift down
  logic signed [PROD_W-1:0] sampleExt, gainExt, product, productShift;
  logic [SCALE_W-1:0] scaledNext, scaledReg;

  always_comb begin
    sampleExt    = {{(COEF_W+1){finalSample[DATA_W-1]}}, finalSample};
    gainExt      = {{(DATA_W+1){1'b0}}, gainReg};
    product      = sampleExt * gainExt;
    productShift = product >>> GAIN_SHIFT;
    scaledNext   = productShift[SCALE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               scaledReg <= '0;
    else if (strobes.stepMul) scaledReg <= scaledNext;
  end

  // offset stage: sign-extended, left-shifted offset added after scaling
  logic [SUM_W-1:0] offsetTerm, sumWide;
  logic [DATA_W-1:0] clipped, outReg;

  always_comb begin
    offsetTerm = {{OFS_PAD{offsetReg[COEF_W-1]}}, offsetReg, {OFFSET_SHIFT{1'b0}}};
    sumWide    = {scaledReg[SCALE_W-1], scaledReg} + offsetTerm;
  end

  trim_saturate #(.IN_W(SUM_W), .OUT_W(DATA_W)) u_sat (
    .valueIn (sumWide),
    .valueOut(clipped)
  );

  always_ff @(posedge clk) begin
    if (!rstN)               outReg <= '0;
    else if (strobes.stepSum) outReg <= clipped;
  end

  assign outSample = outReg;

  // early overrange compare on the untrimmed first-stage sample
  logic [COEF_W-1:0] upperBits;
  logic [COEF_W:0]   upperExt, upperMag;
  logic [COEF_W+1:0] magScaled, limitScaled;

  always_comb begin
    upperBits   = earlySample[DATA_W-1 -: COEF_W];
    upperExt    = {upperBits[COEF_W-1], upperBits};
    upperMag    = upperExt[COEF_W] ? (~upperExt + {{COEF_W{1'b0}}, 1'b1}) : upperExt;
    magScaled   = {upperMag, 1'b0};
    limitScaled = {2'b00, limitReg};
    earlyHit    = magScaled > limitScaled;
  end
endmodule

// File: rtl/trim_control.sv
module trim_control
  import trim_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int RUN_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             finalValid,
  input  logic             earlyValid,
  input  logic             earlyHit,
  input  logic             modValid,
  input  logic             modOverFs,
  input  logic             statusRead,
  output trimStrobes_t     strobes,
  output logic             outValid,
  output logic             overrange,
  output logic             runFull,
  output logic             earlyTrip,
  output logic             runTrip
);
  localparam int CNT_W = $clog2(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_LIMIT);

  logic mulValid, sumValid, flagReg;
  logic [CNT_W-1:0] runCount;

  always_comb begin
    strobes.loadGain   = cfgWrite && (cfgSel == SEL_GAIN);
    strobes.loadOffset = cfgWrite && (cfgSel == SEL_OFFSET);
    strobes.loadLimit  = cfgWrite && (cfgSel == SEL_LIMIT);
    strobes.stepMul    = finalValid;
    strobes.stepSum    = mulValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mulValid <= 1'b0;
      sumValid <= 1'b0;
    end else begin
      mulValid <= finalValid;
      sumValid <= mulValid;
    end
  end

  assign outValid = sumValid;

  assign runFull = (runCount == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rstN)
      runCount <= '0;
    else if (modValid) begin
      if (!modOverFs)      runCount <= '0;
      else if (!runFull)   runCount <= runCount + 1'b1;
    end
  end

  assign runTrip   = modValid && modOverFs && runFull;
  assign earlyTrip = earlyValid && earlyHit;

  always_ff @(posedge clk) begin
    if (!rstN)                     flagReg <= 1'b0;
    else if (runTrip || earlyTrip) flagReg <= 1'b1;
    else if (statusRead)           flagReg <= 1'b0;
  end

  assign overrange = flagReg;
endmodule

// File: rtl/trim_corrector.sv
module trim_corrector
  import trim_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int COEF_W       = 16,
  parameter int SEL_W        = 2,
  parameter int GAIN_SHIFT   = 15,
  parameter int OFFSET_SHIFT = 1,
  parameter int RUN_LIMIT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [COEF_W-1:0] cfgData,
  input  logic              finalValid,
  input  logic [DATA_W-1:0] finalSample,
  input  logic              earlyValid,
  input  logic [DATA_W-1:0] earlySample,
  input  logic              modValid,
  input  logic              modOverFs,
  input  logic              statusRead,
  output logic              outValid,
  output logic [DATA_W-1:0] outSample,
  output logic              overrange
);
  trimStrobes_t strobes;
  logic earlyHit, runFull, earlyTrip, runTrip;
  logic [COEF_W-1:0] gainNow, offsetNow, limitNow;

  trim_control #(.SEL_W(SEL_W), .RUN_LIMIT(RUN_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .finalValid(finalValid), .earlyValid(earlyValid), .earlyHit(earlyHit),
    .modValid(modValid), .modOverFs(modOverFs), .statusRead(statusRead),
    .strobes(strobes), .outValid(outValid), .overrange(overrange),
    .runFull(runFull), .earlyTrip(earlyTrip), .runTrip(runTrip)
  );

  trim_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W),
    .GAIN_SHIFT(GAIN_SHIFT), .OFFSET_SHIFT(OFFSET_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgData(cfgData),
    .finalSample(finalSample), .earlySample(earlySample),
    .outSample(outSample), .earlyHit(earlyHit),
    .gainNow(gainNow), .offsetNow(offsetNow), .limitNow(limitNow)
  );
endmodule

// File: rtl/trim_corrector_checker.sv
module trim_corrector_checker #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              finalValid,
  input logic [DATA_W-1:0] finalSample,
  input logic              earlyValid,
  input logic [DATA_W-1:0] earlySample,
  input logic              modValid,
  input logic              modOverFs,
  input logic              statusRead,
  input logic              outValid,
  input logic [DATA_W-1:0] outSample,
  input logic              overrange,
  input logic [COEF_W-1:0] gainNow,
  input logic [COEF_W-1:0] offsetNow,
  input logic [COEF_W-1:0] limitNow,
  input logic              runFull
);
  localparam int PAD_W = DATA_W - COEF_W - 1;

  logic [COEF_W-1:0] upper;
  logic [COEF_W:0]   upExt, upMag;
  logic              bigEarly;
  always_comb begin
    upper    = earlySample[DATA_W-1 -: COEF_W];
    upExt    = {upper[COEF_W-1], upper};
    upMag    = upExt[COEF_W] ? (~upExt + {{COEF_W{1'b0}}, 1'b1}) : upExt;
    bigEarly = {upMag, 1'b0} > {2'b00, limitNow};
  end

  // R5: every accepted sample leaves two edges later
  a_r5_latency_fwd: assert property (@(posedge clk) disable iff (!rstN)
    finalValid |-> ##2 outValid);
  a_r5_latency_back: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(finalValid, 2));

  // R2: unity gain and zero offset pass the sample through
  a_r2_unity_pass: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(gainNow, 2) == 16'h8000 && $past(offsetNow, 1) == '0)
      |-> outSample == $past(finalSample, 2));

  // R3: a zero sample yields exactly the scaled offset
  a_r3_offset_only: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(finalSample, 2) == '0)
      |-> outSample == {{PAD_W{$past(offsetNow[COEF_W-1], 1)}}, $past(offsetNow, 1), 1'b0});

  // R7: early threshold crossing sets the flag
  a_r7_early_sets: assert property (@(posedge clk) disable iff (!rstN)
    (earlyValid && bigEarly) |=> overrange);

  // R8: fifth consecutive over-scale modulator sample sets the flag
  a_r8_run_sets: assert property (@(posedge clk) disable iff (!rstN)
    (modValid && modOverFs && runFull) |=> overrange);

  // R9: sticky until read, read clears when nothing triggers
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrange && !statusRead) |=> overrange);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(earlyValid && bigEarly) && !(modValid && modOverFs && runFull))
      |=> !overrange);
endmodule

bind trim_corrector trim_corrector_checker #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rstN(rstN), .finalValid(finalValid), .finalSample(finalSample),
  .earlyValid(earlyValid), .earlySample(earlySample), .modValid(modValid),
  .modOverFs(modOverFs), .statusRead(statusRead), .outValid(outValid),
  .outSample(outSample), .overrange(overrange), .gainNow(gainNow),
  .offsetNow(offsetNow), .limitNow(limitNow), .runFull(runFull)
);

// File: tb/trim_corrector_test.sv
module trim_corrector_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic finalValid = 1'b0;
  logic [23:0] finalSample = '0;
  logic earlyValid = 1'b0;
  logic [23:0] earlySample = '0;
  logic modValid = 1'b0;
  logic modOverFs = 1'b0;
  logic statusRead = 1'b0;
  logic outValid;
  logic [23:0] outSample;
  logic overrange;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] gainM = 16'hA000;
  logic [15:0] offsetM = 16'h0000;
  logic [15:0] limitM = 16'hCCCC;

  always #(CLK_PERIOD/2) clk = ~clk;

  trim_corrector uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgData(cfgData),
    .finalValid(finalValid), .finalSample(finalSample),
    .earlyValid(earlyValid), .earlySample(earlySample),
    .modValid(modValid), .modOverFs(modOverFs), .statusRead(statusRead),
    .outValid(outValid), .outSample(outSample), .overrange(overrange)
  );

  function automatic logic [23:0] trimModel(logic [23:0] s, logic [15:0] g, logic [15:0] o);
    longint sv, prod, sum;
    sv   = longint'($signed(s));
    prod = (sv * longint'(g)) >>> 15;
    sum  = prod + longint'($signed(o)) * 2;
    if (sum > 64'sd8388607) sum = 64'sd8388607;
    if (sum < -64'sd8388608) sum = -64'sd8388608;
    return sum[23:0];
  endfunction

  function automatic logic earlyModel(logic [23:0] s, logic [15:0] lim);
    longint h;
    h = longint'($signed(s[23:8]));
    if (h < 0) h = -h;
    return (2 * h) > longint'(lim);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [1:0] sel, logic [15:0] data);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWrite = 1'b0;
    case (sel)
      2'd0: gainM = data;
      2'd1: offsetM = data;
      2'd2: limitM = data;
      default: ;
    endcase
  endtask

  task automatic runSample(logic [23:0] s, string req);
    logic [23:0] exp;
    exp = trimModel(s, gainM, offsetM);
    @(negedge clk);
    finalValid = 1'b1; finalSample = s;
    @(negedge clk);
    finalValid = 1'b0;
    if (outValid !== 1'b0) check("R5 early valid", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    check("R5 valid", {31'd0, outValid}, 32'd1);
    check(req, {8'd0, outSample}, {8'd0, exp});
    @(negedge clk);
    if (outValid !== 1'b0) check("R5 single", {31'd0, outValid}, 32'd0);
  endtask

  task automatic clearFlag();
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic earlyPulse(logic [23:0] s, string req);
    logic exp;
    exp = earlyModel(s, limitM);
    @(negedge clk);
    earlyValid = 1'b1; earlySample = s;
    @(negedge clk);
    earlyValid = 1'b0;
    check(req, {31'd0, overrange}, {31'd0, exp});
    if (overrange) clearFlag();
  endtask

  task automatic modPulse(logic over);
    @(negedge clk);
    modValid = 1'b1; modOverFs = over;
    @(negedge clk);
    modValid = 1'b0; modOverFs = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 outValid", {31'd0, outValid}, 32'd0);
    check("R1 overrange", {31'd0, overrange}, 32'd0);
    check("R1 outSample", {8'd0, outSample}, 32'd0);
    // R1 reset gain 1.25: 0x100000 -> 0x140000
    runSample(24'h100000, "R1 R2 reset gain");
    check("R1 gain value", {8'd0, outSample}, 32'h140000);
    // R1 reset limit 0xCCCC: 26214 no trip, 26215 trip
    earlyPulse(24'h666600, "R1 R7 below limit");
    earlyPulse(24'h666700, "R1 R7 above limit");
    earlyPulse(-24'sh666700, "R7 negative above");
    earlyPulse(-24'sh666600, "R7 negative below");

    // R2 unity gain
    writeCfg(2'd0, 16'h8000);
    runSample(24'h123456, "R2 unity");
    runSample(24'hFEDCBA, "R2 unity negative");
    // R2 floor on negative odd product
    writeCfg(2'd0, 16'h4000);
    runSample(24'hFFFFFF, "R2 half floor");

    // R3 offset after gain
    writeCfg(2'd1, 16'h7FFF);
    runSample(24'h000000, "R3 positive offset");
    writeCfg(2'd1, 16'h8000);
    runSample(24'h000000, "R3 negative offset");
    runSample(24'h200000, "R3 gain then offset");

    // R4 saturation
    writeCfg(2'd0, 16'hFFFF);
    writeCfg(2'd1, 16'h0000);
    runSample(24'h7FFFFF, "R4 positive clip");
    check("R4 max", {8'd0, outSample}, 32'h7FFFFF);
    runSample(24'h800000, "R4 negative clip");
    check("R4 min", {8'd0, outSample}, 32'h800000);
    writeCfg(2'd0, 16'h8000);
    writeCfg(2'd1, 16'h7FFF);
    runSample(24'h7FFF00, "R4 offset clip high");
    writeCfg(2'd1, 16'h8000);
    runSample(24'h800100, "R4 offset clip low");

    // R6 spare select ignored
    writeCfg(2'd3, 16'h1234);
    runSample(24'h000400, "R6 spare ignored");

    // R6 limit write and R7 independence from trim
    writeCfg(2'd2, 16'h1000);
    writeCfg(2'd0, 16'h0001);
    earlyPulse(24'h080100, "R6 R7 new limit above");
    earlyPulse(24'h080000, "R6 R7 new limit equal");

    // R8 run detection
    clearFlag();
    repeat (4) modPulse(1'b1);
    check("R8 four not enough", {31'd0, overrange}, 32'd0);
    modPulse(1'b1);
    check("R8 fifth trips", {31'd0, overrange}, 32'd1);
    // R9 sticky across idle
    repeat (5) @(negedge clk);
    check("R9 sticky", {31'd0, overrange}, 32'd1);
    modPulse(1'b0);
    clearFlag();
    check("R9 cleared", {31'd0, overrange}, 32'd0);
    repeat (4) modPulse(1'b1);
    modPulse(1'b0);
    repeat (4) modPulse(1'b1);
    check("R8 broken run", {31'd0, overrange}, 32'd0);
    modPulse(1'b0);

    // R9 read coincident with trigger keeps flag
    @(negedge clk);
    statusRead = 1'b1; earlyValid = 1'b1; earlySample = 24'h7FFFFF;
    @(negedge clk);
    statusRead = 1'b0; earlyValid = 1'b0;
    check("R9 trigger beats read", {31'd0, overrange}, 32'd1);
    clearFlag();
    check("R9 read clears", {31'd0, overrange}, 32'd0);

    // random trim
    for (int i = 0; i < 300; i++) begin
      logic [23:0] s;
      if (($urandom % 8) == 0) writeCfg(2'd0, 16'($urandom));
      if (($urandom % 8) == 0) writeCfg(2'd1, 16'($urandom));
      case ($urandom % 6)
        0: s = 24'h7FFFFF;
        1: s = 24'h800000;
        default: s = 24'($urandom);
      endcase
      runSample(s, "R2 R3 R4 random");
    end

    // random early compare
    for (int i = 0; i < 60; i++) begin
      if (($urandom % 4) == 0) writeCfg(2'd2, 16'($urandom));
      earlyPulse(24'($urandom), "R7 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule